// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This block is one execution slice of a 32-bit soft processor. It takes two operands, `a` and `b`, and a two-bit operation code. It produces one 32-bit result word, using one of three operations:

- **Signed compare** and **unsigned compare** both return the difference `b - a`. When the two operands have different sign bits, the top bit of that difference is patched. After the patch, bit 31 of the result alone says whether `b` is below `a` under the chosen ordering.
- **Byte find** scans the byte lanes starting from the most significant one. It reports the 1-based position of the first lane in which both operands hold the same byte.

The result is computed combinationally. It is captured in an output register when `in_valid` is high and is presented with `out_valid` one cycle later. The registered word holds its value until the next accepted request.

Top module: `cmp_bytefind_unit`

## Requirements
- R1: With op = 2'b00 (signed compare), when `a[31]` and `b[31]` differ, result bits 30:0 equal bits 30:0 of `b - a` and result bit 31 equals `b[31]`.
- R2: With op = 2'b01 (unsigned compare), when `a[31]` and `b[31]` differ, result bits 30:0 equal bits 30:0 of `b - a` and result bit 31 equals `a[31]`.
- R3: With op = 2'b00 or 2'b01, when `a[31]` equals `b[31]`, the result is exactly `b - a` modulo 2^32, with no bit patched.
- R4: With op = 2'b10 (byte find), lanes are examined in the order bits 31:24, 23:16, 15:8, 7:0. The result is 1, 2, 3 or 4 for the first lane in that order where `a` and `b` are equal, and 0 when no lane matches. The upper result bits are zero.
- R5: With op = 2'b11 (reserved), the result is zero.
- R6: A request accepted with `in_valid` high at a rising clock edge makes `out_valid` high for the following cycle, carrying that request's result. A cycle without `in_valid` makes `out_valid` low in the next cycle.
- R7: While `rst_n` is low, `out_valid` is low and the result register is zero.
- R8: When `in_valid` is low, the result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| in_valid | input | 1 | Request strobe; operands and op are sampled when high |
| op | input | 2 | Operation: 00 signed compare, 01 unsigned compare, 10 byte find, 11 reserved |
| a | input | 32 | First operand (the subtrahend for the compares) |
| b | input | 32 | Second operand (the minuend for the compares) |
| out_valid | output | 1 | Result word is valid in this cycle |
| result | output | 32 | Registered result word |

## Verification
The clocked properties assume that `op`, `a` and `b` are known and stable at every rising edge where `in_valid` is high. They also assume that reset is released between edges. The bench meets both assumptions by driving all inputs only on falling edges and by deasserting `rst_n` away from a rising edge.

Random operands are mixed with directed pairs: 0x7FFFFFFF against 0x80000000, 0 against 0xFFFFFFFF, equal operands, and byte patterns whose only matching lane sits in each position. Idle cycles are inserted so that the hold and valid-drop behaviour are exercised between requests.

// File: rtl/icbm_pkg.sv
package icbm_pkg;
  typedef enum logic [1:0] {
    OP_SCMP  = 2'b00,
    OP_UCMP  = 2'b01,
    OP_BFIND = 2'b10,
    OP_RSVD  = 2'b11
  } icbm_op_e;
endpackage

// File: rtl/icbm_sub_cmp.sv
// Subtract-and-patch compare: diff = b - a, with the top bit taken from
// one operand when the operand signs disagree.
module icbm_sub_cmp #(
  parameter int W           = 32,
  parameter bit SIGN_FROM_A = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff
);
  localparam int MSB = W - 1;

  logic [W-1:0] raw;
  logic         sign_split;
  logic         patch_bit;

  always_comb begin
    raw        = b + ~a + {{(W-1){1'b0}}, 1'b1};
    sign_split = a[MSB] ^ b[MSB];
  end

  generate
    if (SIGN_FROM_A) begin : g_from_a
      always_comb patch_bit = a[MSB];
    end else begin : g_from_b
      always_comb patch_bit = b[MSB];
    end
  endgenerate

  always_comb begin
    diff      = raw;
    diff[MSB] = sign_split ? patch_bit : raw[MSB];
  end
endmodule

// File: rtl/icbm_byte_find.sv
// Most-significant-first byte lane match, 1-based index, 0 when none.
module icbm_byte_find #(
  parameter int W    = 32,
  parameter int LANE = 8,
  localparam int NL  = W / LANE,
  localparam int IW  = $clog2(NL + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [IW-1:0] idx
);
  logic [NL-1:0] lane_eq;

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      assign lane_eq[g] = (a[g*LANE +: LANE] == b[g*LANE +: LANE]);
    end
  endgenerate

  // Walk upward from lane 0; later (higher) lanes override, so the most
  // significant matching lane wins.
  always_comb begin
    idx = '0;
    for (int i = 0; i < NL; i++) begin
      if (lane_eq[i]) idx = IW'(NL - i);
    end
  end
endmodule

// File: rtl/icbm_out_reg.sv
module icbm_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);
  logic         vld_nx;
  logic [W-1:0] q_nx;

  always_comb begin
    vld_nx = load;
    q_nx   = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= vld_nx;
      q   <= q_nx;
    end
  end
endmodule

// File: rtl/cmp_bytefind_unit.sv
module cmp_bytefind_unit
  import icbm_pkg::*;
#(
  parameter int W    = 32,
  parameter int LANE = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int NL  = W / LANE;
  localparam int IW  = $clog2(NL + 1);
  localparam int MSB = W - 1;

  icbm_op_e     op_e;
  logic [W-1:0] s_diff;
  logic [W-1:0] u_diff;
  logic [IW-1:0] find_idx;
  logic [W-1:0] res_comb;

  assign op_e = icbm_op_e'(op);

  icbm_sub_cmp #(.W(W), .SIGN_FROM_A(1'b0)) u_scmp (
    .a(a), .b(b), .diff(s_diff)
  );

  icbm_sub_cmp #(.W(W), .SIGN_FROM_A(1'b1)) u_ucmp (
    .a(a), .b(b), .diff(u_diff)
  );

  icbm_byte_find #(.W(W), .LANE(LANE)) u_find (
    .a(a), .b(b), .idx(find_idx)
  );

  always_comb begin
    unique case (op_e)
      OP_SCMP:  res_comb = s_diff;
      OP_UCMP:  res_comb = u_diff;
      OP_BFIND: res_comb = {{(W-IW){1'b0}}, find_idx};
      default:  res_comb = '0;
    endcase
  end

  icbm_out_reg #(.W(W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .d(res_comb),
    .vld(out_valid), .q(result)
  );

  // R1: signed compare with split signs takes its top bit from b
  p_signed_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00 && (a[MSB] != b[MSB])) |=> (result[MSB] == $past(b[MSB])));

  // R2: unsigned compare with split signs takes its top bit from a
  p_unsigned_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01 && (a[MSB] != b[MSB])) |=> (result[MSB] == $past(a[MSB])));

  // R3: equal signs give the plain difference
  p_plain_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[1] && (a[MSB] == b[MSB])) |=> (result == $past(b - a)));

  // R4: a matching top lane always reports position 1
  p_top_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10 && (a[MSB -: LANE] == b[MSB -: LANE])) |=> (result == W'(1)));

  // R5: reserved code yields zero
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> (result == '0));

  // R6: valid follows the request by one cycle
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8: idle cycles keep the result word
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && !out_valid));
endmodule

// File: tb/tb_cmp_bytefind_unit.sv
`timescale 1ns/1ps
module tb_cmp_bytefind_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [31:0] a, b;
  logic        out_valid;
  logic [31:0] result;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q_exp[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] last_res;

  cmp_bytefind_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [31:0] model(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] d;
    d = y - x;
    case (o)
      2'b00: begin if (x[31] != y[31]) d[31] = y[31]; return d; end
      2'b01: begin if (x[31] != y[31]) d[31] = x[31]; return d; end
      2'b10: begin
        for (int k = 0; k < 4; k++)
          if (x[31-8*k -: 8] == y[31-8*k -: 8]) return 32'(k + 1);
        return 32'd0;
      end
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    if (o == 2'b10) return "R4";
    if (o == 2'b11) return "R5";
    if (x[31] == y[31]) return "R3";
    return (o == 2'b00) ? "R1" : "R2";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] o, logic [31:0] x, logic [31:0] y, logic [31:0] exp, string req);
    item_t it;
    @(negedge clk);
    in_valid = 1; op = o; a = x; b = y;
    it.exp = exp; it.req = req;
    q_exp.push_back(it);
  endtask

  task automatic send_m(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    send(o, x, y, model(o, x, y), tag(o, x, y));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; op = $urandom; a = $urandom; b = $urandom;
    end
  endtask

  // Monitor: pop and compare whenever a result is presented
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 actual=out_valid expected=no pending item");
      end else begin
        item_t it;
        it = q_exp.pop_front();
        check(it.req, result, it.exp);
      end
    end
  end

  initial begin
    in_valid = 0; op = 0; a = 0; b = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R7", {31'd0, out_valid}, 32'd0);
    check("R7", result, 32'd0);
    rst_n = 1;

    // Directed boundary pairs (R1/R2/R3)
    send(2'b00, 32'h7FFFFFFF, 32'h80000000, 32'h80000001, "R1");
    send(2'b01, 32'h7FFFFFFF, 32'h80000000, 32'h00000001, "R2");
    send(2'b00, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
    send(2'b01, 32'h00000000, 32'hFFFFFFFF, 32'h7FFFFFFF, "R2");
    send(2'b00, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, "R1");
    send(2'b01, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, "R2");
    send(2'b00, 32'h12345678, 32'h12345678, 32'h00000000, "R3");
    send(2'b01, 32'hDEADBEEF, 32'hDEADBEEF, 32'h00000000, "R3");
    send(2'b01, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, "R3");
    // Byte find (R4)
    send(2'b10, 32'h11223344, 32'h11223344, 32'd1, "R4");
    send(2'b10, 32'h11223344, 32'h99223344, 32'd2, "R4");
    send(2'b10, 32'hAABBCC44, 32'h00112244, 32'd4, "R4");
    send(2'b10, 32'hAA33CC44, 32'h00332211, 32'd2, "R4");
    send(2'b10, 32'h0000CC00, 32'h1111CC11, 32'd3, "R4");
    send(2'b10, 32'h01020304, 32'h10203040, 32'd0, "R4");
    // Reserved (R5)
    send(2'b11, 32'h12345678, 32'h9ABCDEF0, 32'd0, "R5");
    idle(1);
    // R6/R8: after an idle cycle out_valid drops and result is held
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd0);
    check("R8", result, 32'd0);

    send(2'b00, 32'h00000010, 32'h00000030, 32'h00000020, "R3");
    idle(1);
    last_res = 32'h00000020;
    idle(2);
    check("R8", result, last_res);
    check("R6", {31'd0, out_valid}, 32'd0);

    // Random traffic with occasional gaps
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (i % 5 == 0) y[23:16] = x[23:16];
      if (i % 7 == 0) x[31] = ~y[31];
      send_m(2'($urandom), x, y);
      if (i % 11 == 0) idle(1);
    end
    idle(3);
    check("R6", 32'(q_exp.size()), 32'd0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule